// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block sits between two bidirectional data buses, called side A and side B, and moves a word from one to the other in either direction. Each side owns a capture register. The register on side A samples the A bus on every rising edge of its own clock, and the register on side B samples the B bus on every rising edge of a second, independent clock. For each direction a select input decides what reaches the far bus: either the live word from the source bus, or the word held in that source side's register.

An active-low transfer enable and a direction input decide which bus, if either, is driven. While the enable is high, both buses are isolated, but the registers go on capturing. Each bidirectional bus is modelled as three vectors: an input vector from the pads, an output vector carrying the word the block would drive, and an output-enable vector. The output-enable vector is all ones while that bus is driven and all zeros otherwise. A live path reads only the source bus's input vector, so no loop can form through the block's own drivers. An optional synchronous reset clears both registers.

Top module: `dual_reg_bus_xcvr`

## Requirements
- R1: The data width is the parameter W (default 8), and every output word is a non-inverted copy of the selected data.
- R2: On each rising edge of `cap_a_clk`, the side-A register loads the value on `a_in`.
- R3: On each rising edge of `cap_b_clk`, the side-B register loads the value on `b_in`.
- R4: Register capture happens on every rising edge, whatever the values of `xfer_en_n` and `toward_b`. This includes edges that arrive while both buses are isolated.
- R5: When `xfer_en_n` is 1, `a_oe` and `b_oe` are both all zeros.
- R6: When `xfer_en_n` is 0 and `toward_b` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R7: When `xfer_en_n` is 0 and `toward_b` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R8: When `a_hold_sel` is 0, `b_out` equals `a_in` combinationally (live mode). `b_out` carries its word whether or not `b_oe` is set.
- R9: When `a_hold_sel` is 1, `b_out` equals the side-A register, and later changes on `a_in` have no effect until the next `cap_a_clk` edge (stored mode).
- R10: When `b_hold_sel` is 0, `a_out` equals `b_in`. When `b_hold_sel` is 1, `a_out` equals the side-B register.
- R11: In stored mode, a capture edge is followed at once by the newly captured word on the far output.
- R12: A live path depends only on the source side's input vector: changing `b_in` leaves `b_out` unchanged, and changing `a_in` leaves `a_out` unchanged.
- R13: With HAS_RESET=1, `rst_sync` high at a rising edge of a side's clock clears that side's register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_a_clk | input | 1 | Rising edge captures `a_in` into the side-A register |
| cap_b_clk | input | 1 | Rising edge captures `b_in` into the side-B register |
| rst_sync | input | 1 | Synchronous register clear, active high, sampled on each side's clock |
| xfer_en_n | input | 1 | Active-low transfer enable; 1 isolates both buses |
| toward_b | input | 1 | 1 drives bus B, 0 drives bus A |
| a_hold_sel | input | 1 | A-to-B source: 0 live `a_in`, 1 side-A register |
| b_hold_sel | input | 1 | B-to-A source: 0 live `b_in`, 1 side-B register |
| a_in | input | W | Word present on bus A pads |
| a_out | output | W | Word offered to bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Word present on bus B pads |
| b_out | output | W | Word offered to bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The overlap that matters is a capture edge arriving while the same path is in stored mode: in that cycle the register load and the far output's change coincide, and the far output must show the new word immediately after the edge. The bench provokes this by holding the stored select and stepping the source word across an edge. It also changes the source word again between edges, which must leave the output untouched. A second overlap is capture during isolation: the registers are loaded with both enables low and then read back in stored mode. Every cycle is judged against a behavioural model of both registers and the function table.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } path_src_e;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_t;

  // Decode of the transfer enable and direction into per-bus drive flags.
  function automatic drive_t decode_drive(input logic en_n, input logic to_b);
    drive_t d;
    d.drive_b = ~en_n & to_b;
    d.drive_a = ~en_n & ~to_b;
    return d;
  endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end

      // R13: reset at an edge leaves the register cleared
      a_r13_clear: assert property (@(posedge clk) rst |=> (q == '0));
    end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) q <= d;
    end
  endgenerate

  // R2/R3/R4: every edge loads the bus word, with no gating
  a_r4_capture_every_edge: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int W = 8
) (
  input  xcvr_pkg::path_src_e src,
  input  logic [W-1:0]        live,
  input  logic [W-1:0]        stored,
  output logic [W-1:0]        y
);
  import xcvr_pkg::*;

  always_comb begin
    unique case (src)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end

endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl #(
  parameter int W = 8
) (
  input  logic         en_n,
  input  logic         to_b,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);
  import xcvr_pkg::*;

  drive_t drv;
  assign drv = decode_drive(en_n, to_b);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign a_oe[i] = drv.drive_a;
    assign b_oe[i] = drv.drive_b;
  end

  always_comb begin
    // R6/R7: a bus is never driven from both sides at once
    a_r6_one_side: assert ($onehot0({|a_oe, |b_oe}));
    // R7: enables switch the whole word together
    a_r7_full_word: assert ((a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));
    // R5: isolation drives nothing
    if (en_n) a_r5_isolated: assert (a_oe == '0 && b_oe == '0);
  end

endmodule

// File: rtl/dual_reg_bus_xcvr.sv
module dual_reg_bus_xcvr #(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         cap_a_clk,
  input  logic         cap_b_clk,
  input  logic         rst_sync,
  input  logic         xfer_en_n,
  input  logic         toward_b,
  input  logic         a_hold_sel,
  input  logic         b_hold_sel,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  import xcvr_pkg::*;

  // Named internal events for the checks below.
  logic [W-1:0] reg_a_q;
  logic [W-1:0] reg_b_q;
  path_src_e    src_a2b;
  path_src_e    src_b2a;

  assign src_a2b = a_hold_sel ? SRC_STORED : SRC_LIVE;
  assign src_b2a = b_hold_sel ? SRC_STORED : SRC_LIVE;

  xcvr_capture_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_reg_a (
    .clk(cap_a_clk), .rst(rst_sync), .d(a_in), .q(reg_a_q)
  );

  xcvr_capture_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_reg_b (
    .clk(cap_b_clk), .rst(rst_sync), .d(b_in), .q(reg_b_q)
  );

  // Live inputs come only from the pad-side vectors (R12).
  xcvr_path_mux #(.W(W)) u_mux_a2b (
    .src(src_a2b), .live(a_in), .stored(reg_a_q), .y(b_out)
  );

  xcvr_path_mux #(.W(W)) u_mux_b2a (
    .src(src_b2a), .live(b_in), .stored(reg_b_q), .y(a_out)
  );

  xcvr_drive_ctrl #(.W(W)) u_drive (
    .en_n(xfer_en_n), .to_b(toward_b), .a_oe(a_oe), .b_oe(b_oe)
  );

  always_comb begin
    // R8: live A-to-B path follows the A pads
    if (!a_hold_sel) a_r8_live_a2b: assert (b_out == a_in);
    // R10: live B-to-A path follows the B pads
    if (!b_hold_sel) a_r10_live_b2a: assert (a_out == b_in);
  end

  // R11: stored A-to-B output shows the word captured at the last edge
  a_r11_stored_a2b: assert property (@(posedge cap_a_clk) disable iff (rst_sync)
    a_hold_sel |=> (!a_hold_sel || b_out == $past(a_in)));

  // R11: same for the B-to-A path
  a_r11_stored_b2a: assert property (@(posedge cap_b_clk) disable iff (rst_sync)
    b_hold_sel |=> (!b_hold_sel || a_out == $past(b_in)));

endmodule

// File: tb/sim_dual_reg_bus_xcvr.sv
module sim_dual_reg_bus_xcvr;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W = 8;

  logic cap_a_clk = 1'b0;
  logic cap_b_clk = 1'b0;
  logic rst_sync = 1'b1;
  logic xfer_en_n = 1'b1;
  logic toward_b = 1'b0;
  logic a_hold_sel = 1'b0;
  logic b_hold_sel = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_chk = 0;
  int n_err = 0;

  // 125 MHz side-A clock; side-B clock at the same rate, offset by 2 ns.
  always #4 cap_a_clk = ~cap_a_clk;
  initial begin
    #2;
    forever #4 cap_b_clk = ~cap_b_clk;
  end

  dual_reg_bus_xcvr #(.W(W), .HAS_RESET(1'b1)) u0 (
    .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk), .rst_sync(rst_sync),
    .xfer_en_n(xfer_en_n), .toward_b(toward_b),
    .a_hold_sel(a_hold_sel), .b_hold_sel(b_hold_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // Behavioural model: one stored word per side.
  logic [W-1:0] m_a = '0;
  logic [W-1:0] m_b = '0;
  always @(posedge cap_a_clk) m_a <= rst_sync ? '0 : a_in;
  always @(posedge cap_b_clk) m_b <= rst_sync ? '0 : b_in;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    logic [W-1:0] eb, ea, eboe, eaoe;
    eb   = a_hold_sel ? m_a : a_in;
    ea   = b_hold_sel ? m_b : b_in;
    eboe = (!xfer_en_n && toward_b)  ? {W{1'b1}} : {W{1'b0}};
    eaoe = (!xfer_en_n && !toward_b) ? {W{1'b1}} : {W{1'b0}};
    check(req, "b_out", b_out, eb);
    check(req, "a_out", a_out, ea);
    check(req, "b_oe", b_oe, eboe);
    check(req, "a_oe", a_oe, eaoe);
  endtask

  // Wait for the next A edge (B edge follows 2 ns later), sample 3 ns after it.
  task automatic step(input string req);
    @(posedge cap_a_clk);
    #3;
    compare_all(req);
  endtask

  // Sample combinational response between edges.
  task automatic settle(input string req);
    #0.5;
    compare_all(req);
  endtask

  initial begin
    // R13: reset clears both registers
    a_hold_sel = 1'b1; b_hold_sel = 1'b1; xfer_en_n = 1'b0;
    a_in = 8'hAA; b_in = 8'h55;
    step("R13");
    step("R13");
    check("R13", "b_out cleared", b_out, 8'h00);
    check("R13", "a_out cleared", a_out, 8'h00);
    rst_sync = 1'b0;

    // R5 and R4: load both registers while isolated, read back stored
    xfer_en_n = 1'b1; a_hold_sel = 1'b0; b_hold_sel = 1'b0;
    a_in = 8'h3C; b_in = 8'hC3;
    step("R5");
    a_hold_sel = 1'b1; b_hold_sel = 1'b1;
    a_in = 8'h00; b_in = 8'hFF;
    settle("R4");
    check("R4", "b_out isolated capture", b_out, 8'h3C);
    check("R4", "a_out isolated capture", a_out, 8'hC3);

    // R6, R8, R1: drive B from live A, non-inverted
    xfer_en_n = 1'b0; toward_b = 1'b1; a_hold_sel = 1'b0;
    a_in = 8'h0F;
    settle("R6");
    check("R1", "b_out true copy", b_out, 8'h0F);
    check("R6", "b_oe all ones", b_oe, 8'hFF);
    a_in = 8'h5A;
    settle("R8");
    // R12: B pads do not reach b_out
    b_in = 8'h81;
    settle("R12");
    check("R12", "b_out after b_in change", b_out, 8'h5A);

    // R9, R11, R2: stored A-to-B
    a_hold_sel = 1'b1; a_in = 8'h11;
    step("R2");
    check("R11", "b_out new word after edge", b_out, 8'h11);
    a_in = 8'h22;
    settle("R9");
    check("R9", "b_out held between edges", b_out, 8'h11);
    step("R11");
    check("R11", "b_out next word after edge", b_out, 8'h22);

    // R7, R10, R3: drive A; live then stored B-to-A
    toward_b = 1'b0; b_hold_sel = 1'b0; b_in = 8'h96;
    settle("R7");
    check("R7", "a_oe all ones", a_oe, 8'hFF);
    check("R10", "a_out live", a_out, 8'h96);
    a_in = 8'h7E;
    settle("R12");
    check("R12", "a_out after a_in change", a_out, 8'h96);
    b_hold_sel = 1'b1;
    step("R3");
    check("R3", "a_out stored word", a_out, 8'h96);
    b_in = 8'h44;
    settle("R10");
    check("R10", "a_out held between edges", a_out, 8'h96);

    // R4: sweep every control combination with varied data
    for (int i = 0; i < 64; i++) begin
      xfer_en_n  = i[0];
      toward_b   = i[1];
      a_hold_sel = i[2];
      b_hold_sel = i[3];
      a_in = W'($urandom);
      b_in = W'($urandom);
      settle("R4");
      step("R4");
      a_in = W'($urandom);
      b_in = W'($urandom);
      settle("R9");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule